// File: doc/BRIEF.md
# Timer Interrupt Status and Enable Register

This block is the byte-wide control register that a three-channel 16-bit timer places on the CPU bus. It holds one event flag and one interrupt enable for each channel. A channel sets its flag with a single-cycle event pulse. The channel raises that pulse when its counter matches its general register in compare mode, or when the counter is latched into that register in capture mode. The counters and the compare/capture logic sit outside this block and reach it only as these pulses.

Software can remove a flag only by a two-step handshake. It first reads the register while the flag is 1, then writes 0 to that bit. A zero written without that prior read is dropped, and a one written to a flag bit changes nothing. Each channel's interrupt request is a registered AND of its flag and its enable. The enables are ordinary read/write bits. Two reserved bit positions always read as 1.

Top module: `tisr_regblock`

## Requirements
- R1: A synchronous active-high reset clears every flag, enable and armed state and drives `irq` to 0. After reset `rdata` shows 0x88.
- R2: A selected read (`sel` and `rd_stb` high at a clock edge) loads `rdata` at that edge with the image {1, en[2:0], 1, flag[2:0]}: bit 7 and bit 3 are reserved and read 1, bits 6..4 are the enables of channels 2..0, and bits 2..0 are the flags of channels 2..0. `rdata` holds its value between reads.
- R3: A selected write loads `wdata[6:4]` into the enables of channels 2..0. The enables change at no other time.
- R4: An `evt[n]` pulse sets flag n at that clock edge.
- R5: Writing 1 to a flag bit leaves that flag and its armed state unchanged.
- R6: Writing 0 to a flag that software has not read as 1 since its last clear leaves the flag unchanged.
- R7: A selected read that returns flag n as 1 arms channel n. A later selected write with `wdata[n]`=0 then clears flag n and disarms the channel, so each read allows only one clear.
- R8: When a valid clear and `evt[n]` fall in the same cycle, flag n stays 1 and the armed state is consumed.
- R9: `irq[n]` is 1 in the cycle after the edge at which flag n and enable n were both 1, and 0 otherwise.
- R10: Writes to bits 7 and 3 have no effect; those bits still read as 1.
- R11: `rd_stb` and `wr_stb` have no effect while `sel` is low. `rdata`, the flags, the enables and the armed state stay unchanged.
- R12: When a selected read and a selected write fall in the same cycle, the write's clear is judged on the armed state from before that cycle, and the read returns the pre-write image.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sel | input | 1 | Register select from the bus decoder |
| rd_stb | input | 1 | Read strobe |
| wr_stb | input | 1 | Write strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| evt | input | 3 | Per-channel compare/capture event pulses |
| irq | output | 3 | Per-channel interrupt requests |

## Verification
The bench targets the clear handshake. It writes a zero before any read, writes ones to armed flags, tries to reuse one read for two clears, and issues a clear in the same cycle as a fresh event. A design that ignores arming would lose flags to stray zero writes. One that keeps the armed bit after a clear would let a stale read wipe out a later event. One that gives the clear priority would drop an interrupt that arrived during service. The bench also writes zeros to the reserved bits, strobes with `sel` low, and reads and writes in the same cycle. A behavioural model, compared on every clock, catches off-by-one timing on `irq` and `rdata` across a long stretch of mixed random bus and event traffic.

// File: rtl/tisr_pkg.sv
package tisr_pkg;

  // Value that reserved bit positions return on a read.
  localparam logic RSV_BIT = 1'b1;

  // Bus operation decoded from select and strobes.
  typedef enum logic [1:0] {
    OP_IDLE  = 2'b00,
    OP_READ  = 2'b01,
    OP_WRITE = 2'b10,
    OP_BOTH  = 2'b11
  } bus_op_e;

  function automatic int unsigned reg_width(input int unsigned nch);
    return 2 * nch + 2;
  endfunction

endpackage

// File: rtl/tisr_flag_cell.sv
// One event flag and its read-armed bit.
module tisr_flag_cell (
  input  logic clk,
  input  logic rst,
  input  logic evt,
  input  logic rd_hit,
  input  logic wr_hit,
  input  logic wbit,
  output logic flag,
  output logic armed
);

  logic clr_ok;
  logic flag_d;
  logic armed_d;

  // A qualifying clear: a zero written while armed.
  assign clr_ok = wr_hit & ~wbit & armed;

  always_comb begin
    flag_d = flag;
    if (clr_ok) flag_d = 1'b0;
    if (evt)    flag_d = 1'b1;       // hardware set has priority
  end

  always_comb begin
    armed_d = armed;
    if (rd_hit && flag) armed_d = 1'b1;
    if (clr_ok)         armed_d = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flag  <= 1'b0;
      armed <= 1'b0;
    end else begin
      flag  <= flag_d;
      armed <= armed_d;
    end
  end

endmodule

// File: rtl/tisr_enable_bank.sv
// Plain read/write interrupt enables.
module tisr_enable_bank #(
  parameter int NCH = 3
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           wr_hit,
  input  logic [NCH-1:0] wfield,
  output logic [NCH-1:0] en
);

  always_ff @(posedge clk) begin
    if (rst) begin
      en <= '0;
    end else if (wr_hit) begin
      en <= wfield;
    end
  end

endmodule

// File: rtl/tisr_irq_gen.sv
// Registered per-channel request lines.
module tisr_irq_gen #(
  parameter int NCH = 3
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NCH-1:0] flag,
  input  logic [NCH-1:0] en,
  output logic [NCH-1:0] irq
);

  always_ff @(posedge clk) begin
    if (rst) begin
      irq <= '0;
    end else begin
      irq <= flag & en;
    end
  end

endmodule

// File: rtl/tisr_read_port.sv
// Assembles the register image and registers it on a read.
module tisr_read_port #(
  parameter  int NCH = 3,
  localparam int DW  = tisr_pkg::reg_width(NCH)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           rd_hit,
  input  logic [NCH-1:0] flag,
  input  logic [NCH-1:0] en,
  output logic [DW-1:0]  rdata
);

  localparam logic [NCH-1:0] ZERO_N = '0;
  logic [DW-1:0] image;
  logic [DW-1:0] reset_image;

  assign image       = {tisr_pkg::RSV_BIT, en, tisr_pkg::RSV_BIT, flag};
  assign reset_image = {tisr_pkg::RSV_BIT, ZERO_N, tisr_pkg::RSV_BIT, ZERO_N};

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= reset_image;
    end else if (rd_hit) begin
      rdata <= image;
    end
  end

endmodule

// File: rtl/tisr_regblock.sv
// Interrupt status/enable register for a multi-channel timer.
module tisr_regblock #(
  parameter  int NCH = 3,
  localparam int DW  = tisr_pkg::reg_width(NCH)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           sel,
  input  logic           rd_stb,
  input  logic           wr_stb,
  input  logic [DW-1:0]  wdata,
  output logic [DW-1:0]  rdata,
  input  logic [NCH-1:0] evt,
  output logic [NCH-1:0] irq
);

  import tisr_pkg::*;

  // Field placement derived from the channel count.
  localparam int FLG_LO = 0;
  localparam int EN_LO  = NCH + 1;

  bus_op_e        op;
  logic           rd_hit;
  logic           wr_hit;
  logic [NCH-1:0] flag_q;
  logic [NCH-1:0] arm_q;
  logic [NCH-1:0] en_q;

  assign op     = sel ? bus_op_e'({wr_stb, rd_stb}) : OP_IDLE;
  assign rd_hit = (op == OP_READ)  || (op == OP_BOTH);
  assign wr_hit = (op == OP_WRITE) || (op == OP_BOTH);

  for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
    tisr_flag_cell u_flag (
      .clk    (clk),
      .rst    (rst),
      .evt    (evt[ch]),
      .rd_hit (rd_hit),
      .wr_hit (wr_hit),
      .wbit   (wdata[FLG_LO + ch]),
      .flag   (flag_q[ch]),
      .armed  (arm_q[ch])
    );
  end

  tisr_enable_bank #(.NCH(NCH)) u_en (
    .clk    (clk),
    .rst    (rst),
    .wr_hit (wr_hit),
    .wfield (wdata[EN_LO +: NCH]),
    .en     (en_q)
  );

  tisr_irq_gen #(.NCH(NCH)) u_irq (
    .clk  (clk),
    .rst  (rst),
    .flag (flag_q),
    .en   (en_q),
    .irq  (irq)
  );

  tisr_read_port #(.NCH(NCH)) u_rd (
    .clk    (clk),
    .rst    (rst),
    .rd_hit (rd_hit),
    .flag   (flag_q),
    .en     (en_q),
    .rdata  (rdata)
  );

endmodule

// File: rtl/tisr_checker.sv
module tisr_checker #(
  parameter  int NCH = 3,
  localparam int DW  = tisr_pkg::reg_width(NCH)
) (
  input logic           clk,
  input logic           rst,
  input logic           sel,
  input logic           wr_stb,
  input logic [NCH-1:0] evt,
  input logic [NCH-1:0] flag,
  input logic [NCH-1:0] arm,
  input logic [NCH-1:0] en,
  input logic [NCH-1:0] irq,
  input logic [DW-1:0]  rdata
);

  // R4: an event pulse leaves its flag set
  a_r4_event_sets_flag: assert property (@(posedge clk) disable iff (rst)
    (|evt) |=> ((flag & $past(evt)) == $past(evt)));

  // R6: a flag never rises without an event
  a_r6_no_spurious_set: assert property (@(posedge clk) disable iff (rst)
    ((flag & ~$past(flag) & ~$past(evt)) == '0));

  // R7: a flag only falls from the armed state
  a_r7_clear_needs_arm: assert property (@(posedge clk) disable iff (rst)
    ((~flag & $past(flag) & ~$past(arm)) == '0));

  // R7: an armed channel always has its flag set
  a_r7_arm_implies_flag: assert property (@(posedge clk) disable iff (rst)
    ((arm & ~flag) == '0));

  // R9: request is the flag/enable product one cycle late
  a_r9_irq_registered: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq == $past(flag & en)));

  // R3: enables hold without a selected write
  a_r3_enable_hold: assert property (@(posedge clk) disable iff (rst)
    !(sel && wr_stb) |=> $stable(en));

  // R10: reserved positions read as one
  a_r10_reserved_ones: assert property (@(posedge clk) disable iff (rst)
    (rdata[DW-1] && rdata[NCH]));

endmodule

bind tisr_regblock tisr_checker #(.NCH(NCH)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .sel    (sel),
  .wr_stb (wr_stb),
  .evt    (evt),
  .flag   (flag_q),
  .arm    (arm_q),
  .en     (en_q),
  .irq    (irq),
  .rdata  (rdata)
);

// File: tb/sim_tisr_regblock.sv
module sim_tisr_regblock;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       sel = 1'b0;
  logic       rd_stb = 1'b0;
  logic       wr_stb = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic [2:0] evt = 3'b000;
  logic [2:0] irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  tisr_regblock u0 (
    .clk(clk), .rst(rst), .sel(sel), .rd_stb(rd_stb), .wr_stb(wr_stb),
    .wdata(wdata), .rdata(rdata), .evt(evt), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Behavioural reference state.
  bit [2:0] m_flag, m_arm, m_en, m_irq;
  bit [7:0] m_rd;

  always @(posedge clk) begin
    if (rst) begin
      m_flag = 0; m_arm = 0; m_en = 0; m_irq = 0; m_rd = 8'h88;
    end else begin
      bit rd_ok, wr_ok;
      bit [2:0] f_old;
      rd_ok = sel && rd_stb;
      wr_ok = sel && wr_stb;
      f_old = m_flag;
      m_irq = m_flag & m_en;
      if (rd_ok) m_rd = {1'b1, m_en, 1'b1, m_flag};
      for (int i = 0; i < 3; i++) begin
        bit kill;
        kill = wr_ok && !wdata[i] && m_arm[i];
        if (kill) m_flag[i] = 1'b0;
        if (evt[i]) m_flag[i] = 1'b1;
        if (kill) m_arm[i] = 1'b0;
        else if (rd_ok && f_old[i]) m_arm[i] = 1'b1;
      end
      if (wr_ok) m_en = wdata[6:4];
    end
  end

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  // Per-cycle comparison against the model.
  always @(negedge clk) begin
    if (!rst && !done) begin
      chk("R9 irq vs model", {5'b0, irq}, {5'b0, m_irq});
      chk("R2 rdata vs model", rdata, m_rd);
    end
  end

  task automatic bus_read(output logic [7:0] v);
    @(negedge clk); sel = 1; rd_stb = 1;
    @(negedge clk); sel = 0; rd_stb = 0;
    v = rdata;
  endtask

  task automatic bus_write(input logic [7:0] d);
    @(negedge clk); sel = 1; wr_stb = 1; wdata = d;
    @(negedge clk); sel = 0; wr_stb = 0; wdata = 0;
  endtask

  task automatic pulse(input logic [2:0] e);
    @(negedge clk); evt = e;
    @(negedge clk); evt = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] v;
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R1 rdata after reset", rdata, 8'h88);
    chk("R1 irq after reset", {5'b0, irq}, 8'h00);
    bus_read(v); chk("R1 reset image read", v, 8'h88);

    bus_write(8'h70); bus_read(v); chk("R3 enables written", v, 8'hF8);
    pulse(3'b001); bus_write(8'h70);
    bus_read(v); chk("R6 unarmed zero ignored", v, 8'hF9);
    chk("R9 irq ch0", {5'b0, irq}, 8'h01);
    bus_write(8'h77); bus_read(v); chk("R5 write one no effect", v, 8'hF9);
    bus_write(8'h70); bus_read(v); chk("R7 armed clear", v, 8'hF8);
    @(negedge clk); chk("R9 irq drops", {5'b0, irq}, 8'h00);
    pulse(3'b001); bus_write(8'h70);
    bus_read(v); chk("R7 arm consumed by clear", v, 8'hF9);
    // R8: clear and event together
    @(negedge clk); sel = 1; wr_stb = 1; wdata = 8'h70; evt = 3'b001;
    @(negedge clk); sel = 0; wr_stb = 0; wdata = 0; evt = 0;
    bus_read(v); chk("R8 set wins", v, 8'hF9);
    bus_write(8'h70); bus_read(v); chk("R8 clear after re-read", v, 8'hF8);
    bus_write(8'h00); bus_read(v); chk("R10 reserved stay one", v, 8'h88);
    bus_write(8'h70);
    pulse(3'b100); bus_read(v); chk("R4 channel 2 event", v, 8'hFC);
    // R11: strobes without select
    @(negedge clk); rd_stb = 1; wr_stb = 1; wdata = 8'h00;
    @(negedge clk); rd_stb = 0; wr_stb = 0;
    chk("R11 rdata held", rdata, 8'hFC);
    bus_read(v); chk("R11 unselected write ignored", v, 8'hFC);
    // R12: read and write together on armed channel 2
    @(negedge clk); sel = 1; rd_stb = 1; wr_stb = 1; wdata = 8'h70;
    @(negedge clk); sel = 0; rd_stb = 0; wr_stb = 0; wdata = 0;
    chk("R12 read returns pre-write image", rdata, 8'hFC);
    bus_read(v); chk("R12 clear applied", v, 8'hF8);
    bus_write(8'h10); pulse(3'b110);
    @(negedge clk); chk("R9 masked channels", {5'b0, irq}, 8'h00);
    pulse(3'b001); @(negedge clk);
    chk("R9 enabled channel", {5'b0, irq}, 8'h01);
    bus_write(8'h70); @(negedge clk);
    chk("R9 all enabled", {5'b0, irq}, 8'h07);
    bus_read(v); chk("R4 all flags", v, 8'hFF);

    // Mixed random traffic checked by the model.
    for (int n = 0; n < 3000; n++) begin
      @(negedge clk);
      sel    = ($urandom_range(0, 3) != 0);
      rd_stb = ($urandom_range(0, 2) == 0);
      wr_stb = ($urandom_range(0, 2) == 0);
      wdata  = 8'($urandom);
      evt    = ($urandom_range(0, 4) == 0) ? 3'($urandom) : 3'b000;
    end
    @(negedge clk); sel = 0; rd_stb = 0; wr_stb = 0; evt = 0;
    repeat (3) @(negedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule